// File: doc/BRIEF.md
# Z80 Backplane Control Glue

This block sits between a Z80-class processor and an 8-bit card backplane. It copies the processor's address, data and bus strobes onto the backplane and builds two strobes that the processor does not provide directly: an interrupt-acknowledge strobe and a strobe that pulses once per machine cycle. It turns each backplane output driver on or off through explicit enable signals, and it sets the direction of the data path. While a DMA master holds the bus, it releases the address, data and buffered control outputs.

The block also makes the time-state clock. In internal mode the clock runs at half the oscillator rate. In external mode it runs at half the rate of an external clock input. From a power-on reset or an active-low pushbutton it makes a stretched system reset. The priority chain passes straight from its input to its output.

All strobe, enable and pass-through outputs are combinational functions of the inputs in the same cycle. The clock output and the system reset are registered.

Top module: `z80_std_glue`

## Requirements
- R1: `std_intak_n` is 0 exactly when `cpu_iorq_n` and `cpu_m1_n` are both 0.
- R2: `std_mcsync_n` is 0 when `cpu_rd_n` is 0, when `cpu_wr_n` is 0, or when `cpu_iorq_n` and `cpu_m1_n` are both 0. Otherwise it is 1.
- R3: `std_stat1_n` equals `cpu_m1_n`. `std_stat0_oe` is always 0, so that line is never driven.
- R4: `std_rd_n`, `std_wr_n`, `std_iorq_n`, `std_mreq_n` and `std_rfsh_n` equal the processor signals of the same role. `bus_addr` equals `cpu_addr` on all 16 bits. `bus_data_out` equals `cpu_dout`. `cpu_din` equals `bus_data_in`.
- R5: `addr_oe` and `ctl_oe` are 1 when `cpu_busak_n` is 1 and 0 when it is 0. `ctl_oe` covers the buffered strobes and the system reset.
- R6: During bus grant, `std_memex_n` and `std_ioexp_n` stay at 0, `std_busak_n` follows `cpu_busak_n`, `prio_out` follows `prio_in`, and `tstate_clk` keeps running.
- R7: With `ext_clk_sel` = 0, `tstate_clk` is 0 during reset and inverts on every clock edge, so it runs at half the oscillator rate.
- R8: With `ext_clk_sel` = 1, `tstate_clk` inverts once for each rising edge of `ext_clk_in`. The inversion lands on the third clock edge after the rising level is applied.
- R9: `std_sysreset_n` is 0 while `rst_n` is 0. After `rst_n` rises it stays 0 and first reads 1 after clock edge RST_HOLD+3. RST_HOLD defaults to 16, so that is edge 19.
- R10: When `pb_reset_n` goes to 0, `std_sysreset_n` is 0 after the third clock edge and still 1 after the second. When `pb_reset_n` returns to 1, the release follows the same RST_HOLD+3 edge count as R9.
- R11: `bus_data_oe` is 1 only when `cpu_wr_n` is 0 outside bus grant. `cpu_data_oe` is 1 only when `cpu_rd_n` is 0 or the interrupt-acknowledge pair is active, again outside bus grant. With no cycle active, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| pb_reset_n | input | 1 | Pushbutton reset, asynchronous, active low |
| ext_clk_sel | input | 1 | 1 selects the external time-state source |
| ext_clk_in | input | 1 | External clock input, at twice the time-state rate |
| cpu_addr | input | 16 | Processor address |
| cpu_dout | input | 8 | Data driven by the processor |
| cpu_din | output | 8 | Data presented to the processor |
| cpu_m1_n | input | 1 | Processor opcode-fetch marker |
| cpu_mreq_n | input | 1 | Processor memory request |
| cpu_iorq_n | input | 1 | Processor I/O request |
| cpu_rd_n | input | 1 | Processor read |
| cpu_wr_n | input | 1 | Processor write |
| cpu_rfsh_n | input | 1 | Processor refresh strobe |
| cpu_busak_n | input | 1 | Processor bus acknowledge |
| bus_data_in | input | 8 | Data received from the backplane |
| prio_in | input | 1 | Priority chain in |
| bus_addr | output | 16 | Backplane address |
| bus_data_out | output | 8 | Data driven onto the backplane |
| addr_oe | output | 1 | Address driver enable |
| ctl_oe | output | 1 | Enable for the buffered control outputs |
| bus_data_oe | output | 1 | Data driver enable, toward the backplane |
| cpu_data_oe | output | 1 | Data driver enable, toward the processor |
| std_wr_n | output | 1 | Backplane write |
| std_rd_n | output | 1 | Backplane read |
| std_iorq_n | output | 1 | Backplane I/O request |
| std_mreq_n | output | 1 | Backplane memory request |
| std_rfsh_n | output | 1 | Backplane refresh |
| std_mcsync_n | output | 1 | Machine-cycle sync |
| std_stat1_n | output | 1 | Opcode-fetch status |
| std_stat0_oe | output | 1 | Second status line enable, always 0 |
| std_intak_n | output | 1 | Interrupt acknowledge |
| std_sysreset_n | output | 1 | Stretched system reset |
| std_busak_n | output | 1 | Bus acknowledge |
| std_memex_n | output | 1 | Memory expansion, strapped low |
| std_ioexp_n | output | 1 | I/O expansion, strapped low |
| prio_out | output | 1 | Priority chain out |
| tstate_clk | output | 1 | Time-state clock |

## Verification
The strobe, enable and pass-through outputs have zero cycles of latency. The bench applies each vector on the falling clock edge and reads the outputs one nanosecond later, within the same cycle.

The internal clock output changes on every rising edge. An external rising edge appears on the clock output at the third rising edge after it is applied, because of two synchroniser flops and one toggle flop.

The system reset falls on the third edge after the pushbutton is pressed and rises on edge RST_HOLD+3 after release. For these registered results, the bench counts rising edges from the falling edge on which it drives the stimulus. It samples one nanosecond after each edge, so each check falls on the exact edge and also on the edge before it.

// File: rtl/z80_std_pkg.sv
// Shared types for the Z80 backplane glue.
// Assumes all processor strobes are active low.
package z80_std_pkg;

    // Processor-side strobe set, all active low
    typedef struct packed {
        logic m1_n;
        logic mreq_n;
        logic iorq_n;
        logic rd_n;
        logic wr_n;
        logic rfsh_n;
    } cpu_ctl_t;

    // Backplane-side strobe set, all active low
    typedef struct packed {
        logic wr_n;
        logic rd_n;
        logic iorq_n;
        logic mreq_n;
        logic rfsh_n;
        logic mcsync_n;
        logic stat1_n;
        logic intak_n;
    } std_ctl_t;

endpackage

// File: rtl/z80_std_sync.sv
// Multi-flop level synchroniser.
// Assumes din is asynchronous to clk. The output lags din by STAGES edges.
module z80_std_sync #(
    parameter int STAGES    = 2,
    parameter bit RST_VALUE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the asynchronous input
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= RST_VALUE;
                    else        chain[0] <= din;
                end
            end else begin : g_next
                // Later stages settle metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= RST_VALUE;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/z80_std_strobes.sv
// Combinational strobe decode and driver-enable logic.
// Assumes the processor never asserts read and write together.
// A bus grant (busak_n low) releases every buffered output.
module z80_std_strobes
    import z80_std_pkg::*;
(
    input  cpu_ctl_t cpu,
    input  logic     busak_n,
    output std_ctl_t std,
    output logic     addr_oe,
    output logic     ctl_oe,
    output logic     bus_data_oe,
    output logic     cpu_data_oe
);
    logic int_ack;
    logic granted;

    assign int_ack = !cpu.iorq_n && !cpu.m1_n;
    assign granted = !busak_n;

    // Map processor strobes to backplane strobes and derive the two composite strobes
    always_comb begin
        std.wr_n     = cpu.wr_n;
        std.rd_n     = cpu.rd_n;
        std.iorq_n   = cpu.iorq_n;
        std.mreq_n   = cpu.mreq_n;
        std.rfsh_n   = cpu.rfsh_n;
        std.stat1_n  = cpu.m1_n;
        std.intak_n  = !int_ack;
        std.mcsync_n = !(!cpu.rd_n || !cpu.wr_n || int_ack);
    end

    // Driver enables and data-path direction
    always_comb begin
        addr_oe     = !granted;
        ctl_oe      = !granted;
        bus_data_oe = !granted && !cpu.wr_n;
        cpu_data_oe = !granted && (!cpu.rd_n || int_ack);
    end
endmodule

// File: rtl/z80_std_clkdiv.sv
// Time-state clock generator.
// Internal mode toggles on every oscillator edge. External mode toggles once
// per synchronised rising edge of the external input.
// Assumes the external input is much slower than clk.
module z80_std_clkdiv #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_sel,
    input  logic ext_in,
    output logic tclk
);
    logic ext_s;
    logic ext_prev;
    logic ext_rise;
    logic advance;

    z80_std_sync #(.STAGES(SYNC_STAGES), .RST_VALUE(1'b0)) u_ext_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ext_in),
        .dout (ext_s)
    );

    // Delay the synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) ext_prev <= 1'b0;
        else        ext_prev <= ext_s;
    end

    assign ext_rise = ext_s && !ext_prev;
    assign advance  = ext_sel ? ext_rise : 1'b1;

    // Toggle the time-state clock on each advance
    always_ff @(posedge clk) begin
        if (!rst_n)       tclk <= 1'b0;
        else if (advance) tclk <= !tclk;
    end

    // R7
    int_mode_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ext_sel)) |-> (tclk != $past(tclk)));

    // R8
    ext_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ext_sel) && $past(ext_s) == $past(ext_prev))
            |-> $stable(tclk));
endmodule

// File: rtl/z80_std_reset.sv
// System reset stretcher.
// Reset is asserted while power-on reset is low or the synchronised pushbutton
// is low, then held for HOLD further edges after both are released.
module z80_std_reset #(
    parameter int HOLD        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pb_n,
    output logic sys_rst_n
);
    localparam int CNT_W = $clog2(HOLD + 1);

    logic             pb_s;
    logic [CNT_W-1:0] hold_cnt;

    z80_std_sync #(.STAGES(SYNC_STAGES), .RST_VALUE(1'b0)) u_pb_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pb_n),
        .dout (pb_s)
    );

    // Reload on trigger, count down after release, then deassert
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt  <= CNT_W'(HOLD);
            sys_rst_n <= 1'b0;
        end else if (!pb_s) begin
            hold_cnt  <= CNT_W'(HOLD);
            sys_rst_n <= 1'b0;
        end else if (hold_cnt != '0) begin
            hold_cnt  <= hold_cnt - 1'b1;
            sys_rst_n <= 1'b0;
        end else begin
            sys_rst_n <= 1'b1;
        end
    end

    // R9
    release_after_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> ($past(pb_s) && pb_s));

    // R10
    press_asserts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pb_s |=> !sys_rst_n);
endmodule

// File: rtl/z80_std_glue.sv
// Z80 to backplane control glue, top level.
// Passes the address, data and strobes through, derives the composite
// strobes, releases the buffered outputs during bus grant, and generates
// the time-state clock and the stretched system reset.
module z80_std_glue
    import z80_std_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int RST_HOLD    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pb_reset_n,
    input  logic              ext_clk_sel,
    input  logic              ext_clk_in,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_dout,
    output logic [DATA_W-1:0] cpu_din,
    input  logic              cpu_m1_n,
    input  logic              cpu_mreq_n,
    input  logic              cpu_iorq_n,
    input  logic              cpu_rd_n,
    input  logic              cpu_wr_n,
    input  logic              cpu_rfsh_n,
    input  logic              cpu_busak_n,
    input  logic [DATA_W-1:0] bus_data_in,
    input  logic              prio_in,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data_out,
    output logic              addr_oe,
    output logic              ctl_oe,
    output logic              bus_data_oe,
    output logic              cpu_data_oe,
    output logic              std_wr_n,
    output logic              std_rd_n,
    output logic              std_iorq_n,
    output logic              std_mreq_n,
    output logic              std_rfsh_n,
    output logic              std_mcsync_n,
    output logic              std_stat1_n,
    output logic              std_stat0_oe,
    output logic              std_intak_n,
    output logic              std_sysreset_n,
    output logic              std_busak_n,
    output logic              std_memex_n,
    output logic              std_ioexp_n,
    output logic              prio_out,
    output logic              tstate_clk
);
    cpu_ctl_t cpu_ctl;
    std_ctl_t std_ctl;

    assign cpu_ctl = '{m1_n: cpu_m1_n, mreq_n: cpu_mreq_n, iorq_n: cpu_iorq_n,
                       rd_n: cpu_rd_n, wr_n: cpu_wr_n, rfsh_n: cpu_rfsh_n};

    z80_std_strobes u_strobes (
        .cpu        (cpu_ctl),
        .busak_n    (cpu_busak_n),
        .std        (std_ctl),
        .addr_oe    (addr_oe),
        .ctl_oe     (ctl_oe),
        .bus_data_oe(bus_data_oe),
        .cpu_data_oe(cpu_data_oe)
    );

    z80_std_clkdiv #(.SYNC_STAGES(SYNC_STAGES)) u_clkdiv (
        .clk    (clk),
        .rst_n  (rst_n),
        .ext_sel(ext_clk_sel),
        .ext_in (ext_clk_in),
        .tclk   (tstate_clk)
    );

    z80_std_reset #(.HOLD(RST_HOLD), .SYNC_STAGES(SYNC_STAGES)) u_reset (
        .clk      (clk),
        .rst_n    (rst_n),
        .pb_n     (pb_reset_n),
        .sys_rst_n(std_sysreset_n)
    );

    // Unpack the backplane strobes onto the ports
    always_comb begin
        std_wr_n     = std_ctl.wr_n;
        std_rd_n     = std_ctl.rd_n;
        std_iorq_n   = std_ctl.iorq_n;
        std_mreq_n   = std_ctl.mreq_n;
        std_rfsh_n   = std_ctl.rfsh_n;
        std_mcsync_n = std_ctl.mcsync_n;
        std_stat1_n  = std_ctl.stat1_n;
        std_intak_n  = std_ctl.intak_n;
    end

    // Plain pass-through paths and always-driven outputs
    assign bus_addr     = cpu_addr;
    assign bus_data_out = cpu_dout;
    assign cpu_din      = bus_data_in;
    assign std_busak_n  = cpu_busak_n;
    assign prio_out     = prio_in;
    assign std_memex_n  = 1'b0;
    assign std_ioexp_n  = 1'b0;
    assign std_stat0_oe = 1'b0;

    // R1
    intak_with_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !std_intak_n |-> !std_mcsync_n);

    // R11
    data_dir_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd_n || cpu_wr_n) |-> $onehot0({bus_data_oe, cpu_data_oe}));

    // R5
    grant_releases_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_oe |-> (!ctl_oe && !bus_data_oe && !cpu_data_oe));
endmodule

// File: tb/z80_std_glue_test.sv
module z80_std_glue_test;
    localparam int HOLD = 16;

    logic        clk = 1'b0;
    logic        rst_n, pb_reset_n, ext_clk_sel, ext_clk_in;
    logic [15:0] cpu_addr, bus_addr;
    logic [7:0]  cpu_dout, cpu_din, bus_data_in, bus_data_out;
    logic        cpu_m1_n, cpu_mreq_n, cpu_iorq_n, cpu_rd_n, cpu_wr_n, cpu_rfsh_n, cpu_busak_n;
    logic        prio_in, prio_out, addr_oe, ctl_oe, bus_data_oe, cpu_data_oe;
    logic        std_wr_n, std_rd_n, std_iorq_n, std_mreq_n, std_rfsh_n, std_mcsync_n;
    logic        std_stat1_n, std_stat0_oe, std_intak_n, std_sysreset_n, std_busak_n;
    logic        std_memex_n, std_ioexp_n, tstate_clk;

    int checks = 0;
    int fails  = 0;

    always #2 clk = !clk;

    z80_std_glue uut (.*);

    // Stimulus {busak_n,m1_n,mreq_n,iorq_n,rd_n,wr_n,rfsh_n}
    // Expected {intak_n,mcsync_n,stat1_n,addr_oe,ctl_oe,bus_data_oe,cpu_data_oe}
    localparam int NV = 10;
    localparam logic [13:0] VEC [NV] = '{
        {7'b1111111, 7'b1111100},  // idle
        {7'b1001011, 7'b1001101},  // opcode fetch
        {7'b1101110, 7'b1111100},  // refresh
        {7'b1101101, 7'b1011110},  // memory write
        {7'b1110011, 7'b1011101},  // I/O read
        {7'b1110101, 7'b1011110},  // I/O write
        {7'b1010111, 7'b0001101},  // interrupt acknowledge
        {7'b0111111, 7'b1110000},  // grant, idle
        {7'b0010111, 7'b0000000},  // grant, stale acknowledge pattern
        {7'b0101101, 7'b1010000}   // grant, write pattern
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_cpu(input logic [6:0] s);
        {cpu_busak_n, cpu_m1_n, cpu_mreq_n, cpu_iorq_n, cpu_rd_n, cpu_wr_n, cpu_rfsh_n} = s;
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic t0;
        int   rise_at;
        int   toggles;
        rst_n = 0; pb_reset_n = 1; ext_clk_sel = 0; ext_clk_in = 0;
        cpu_addr = 16'h0; cpu_dout = 8'h0; bus_data_in = 8'h0; prio_in = 0;
        set_cpu(7'b1111111);
        repeat (4) @(posedge clk);
        #1;
        check("R9 reset low", std_sysreset_n, 0);
        check("R7 tclk low in reset", tstate_clk, 0);

        // Release power-on reset, count edges to the system reset release
        @(negedge clk); rst_n = 1;
        rise_at = 0;
        for (int i = 1; i <= 30; i++) begin
            @(posedge clk); #1;
            if (std_sysreset_n && rise_at == 0) rise_at = i;
        end
        check("R9 release edge", rise_at, HOLD + 3);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            set_cpu(VEC[v][13:7]);
            cpu_addr = 16'hA5C3 ^ 16'(v * 16'h1111);
            cpu_dout = 8'(8'h3C + v);
            bus_data_in = 8'(8'hC0 | v);
            #1;
            check("R1 intak", std_intak_n, VEC[v][6]);
            check("R2 mcsync", std_mcsync_n, VEC[v][5]);
            check("R3 stat1", std_stat1_n, VEC[v][4]);
            check("R5 addr_oe", addr_oe, VEC[v][3]);
            check("R5 ctl_oe", ctl_oe, VEC[v][2]);
            check("R11 bus_data_oe", bus_data_oe, VEC[v][1]);
            check("R11 cpu_data_oe", cpu_data_oe, VEC[v][0]);
            check("R4 strobes", {std_rd_n, std_wr_n, std_iorq_n, std_mreq_n, std_rfsh_n},
                  {cpu_rd_n, cpu_wr_n, cpu_iorq_n, cpu_mreq_n, cpu_rfsh_n});
            check("R4 addr", bus_addr, cpu_addr);
            check("R4 data", {bus_data_out, cpu_din}, {cpu_dout, bus_data_in});
            check("R3 stat0 undriven", std_stat0_oe, 0);
            check("R6 expansion low", {std_memex_n, std_ioexp_n}, 2'b00);
            check("R6 busak", std_busak_n, cpu_busak_n);
        end

        // Outputs that stay driven during grant, including the running clock
        @(negedge clk); set_cpu(7'b0111111);
        for (int p = 0; p < 2; p++) begin
            @(negedge clk); prio_in = p[0]; #1;
            check("R6 prio chain", prio_out, p[0]);
        end
        @(posedge clk); #1; t0 = tstate_clk;
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #1;
            check("R7 R6 internal toggle", tstate_clk, !t0);
            t0 = tstate_clk;
        end

        // External clock mode
        @(negedge clk); set_cpu(7'b1111111); ext_clk_sel = 1; ext_clk_in = 0;
        repeat (4) @(posedge clk);
        #1; t0 = tstate_clk;
        @(negedge clk); ext_clk_in = 1;
        @(posedge clk); @(posedge clk); #1;
        check("R8 no toggle at edge 2", tstate_clk, t0);
        @(posedge clk); #1;
        check("R8 toggle at edge 3", tstate_clk, !t0);
        toggles = 1; t0 = tstate_clk;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); ext_clk_in = 0;
            for (int j = 0; j < 4; j++) begin
                @(posedge clk); #1;
                if (tstate_clk != t0) begin toggles++; t0 = tstate_clk; end
            end
            @(negedge clk); ext_clk_in = 1;
            for (int j = 0; j < 4; j++) begin
                @(posedge clk); #1;
                if (tstate_clk != t0) begin toggles++; t0 = tstate_clk; end
            end
        end
        repeat (6) begin
            @(posedge clk); #1;
            if (tstate_clk != t0) begin toggles++; t0 = tstate_clk; end
        end
        check("R8 one toggle per ext rise", toggles, 5);
        @(negedge clk); ext_clk_sel = 0; ext_clk_in = 0;

        // Pushbutton reset
        @(negedge clk); pb_reset_n = 0;
        @(posedge clk); @(posedge clk); #1;
        check("R10 still high at edge 2", std_sysreset_n, 1);
        @(posedge clk); #1;
        check("R10 low at edge 3", std_sysreset_n, 0);
        repeat (5) @(posedge clk);
        @(negedge clk); pb_reset_n = 1;
        rise_at = 0;
        for (int i = 1; i <= 30; i++) begin
            @(posedge clk); #1;
            if (std_sysreset_n && rise_at == 0) rise_at = i;
        end
        check("R10 release edge", rise_at, HOLD + 3);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule